// File: doc/BRIEF.md
# Scanner-priority system bus arbiter

This block decides which of two masters drives a shared system bus: a PCI bridge and a scanner DMA engine. The scanner presents a level that stays high while its DMA work is active or still waiting. While that level is high, the bridge's request is masked, so the scanner wins every new grant. Arbitration never preempts. The master that holds the bus keeps it until its tenure ends. The scanner ends its tenure with a last signal. The bridge ends its tenure with a last beat, or it is cut off once it has moved a fixed maximum number of data beats.

Grants are registered and one-hot. Between two tenures there is always at least one cycle with no grant, and the next owner is chosen in that cycle. The block also drives a registered request toward the upstream bus owner. It exposes the bridge's beat count for the current tenure, and it raises a single-cycle error when the bridge hits the burst cap without marking a last beat.

Top module: `sysbus_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycles after it, `gnt` is 2'b00, `sys_bus_req` is 0, `burst_err` is 0 and `brg_beats` is 0.
- R2: In a cycle with no grant held, if `scn_pend` is 1 then the following cycle shows `gnt` = 2'b01 (bit 0 = scanner), whatever `brg_req` is.
- R3: The bridge (`gnt` bit 1) is never granted in a cycle that follows a no-grant cycle in which `scn_pend` was 1. With no grant held, `scn_pend` 0 and `brg_req` 1, the next cycle shows `gnt` = 2'b10.
- R4: A held grant is never taken away by the other master's request. The bridge keeps `gnt` = 2'b10 while `scn_pend` rises, until its own tenure ends.
- R5: `gnt` has at most one bit set in every cycle.
- R6: After a cycle in which the owner ends its tenure, the next cycle has `gnt` = 2'b00. The scanner ends its tenure with `scn_last` = 1 while granted. The bridge ends its tenure with `brg_beat` = 1 and `brg_last` = 1 while granted.
- R7: A bridge tenure ends after at most MAX_BEATS (default 8) beats. The beat on which the count reaches MAX_BEATS ends the tenure even when `brg_last` is 0.
- R8: `burst_err` is 1 for exactly the one cycle after the bridge's MAX_BEATS-th beat, when that beat had `brg_last` = 0. It stays 0 when the last beat falls on or before the cap.
- R9: `brg_beats` clears to 0 on each new bridge grant and then counts beats (`brg_beat` = 1 while the bridge is granted). It holds its value between tenures and never exceeds MAX_BEATS.
- R10: `sys_bus_req` is 1 in any cycle in which a grant is held. In every cycle it equals the registered OR of `scn_pend`, `brg_req` and "a grant is held next cycle", taken at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scn_pend | input | 1 | Scanner DMA active or pending; doubles as scanner request |
| scn_last | input | 1 | Scanner marks the end of its tenure |
| brg_req | input | 1 | PCI bridge bus request |
| brg_beat | input | 1 | Bridge data beat this cycle |
| brg_last | input | 1 | Bridge marks the current beat as its last |
| gnt | output | 2 | One-hot grant: bit 0 scanner, bit 1 bridge |
| sys_bus_req | output | 1 | Registered request to the upstream bus owner |
| burst_err | output | 1 | One-cycle flag: bridge hit the burst cap without last |
| brg_beats | output | CNT_W | Beats moved by the bridge in the current or latest tenure |

## Verification
The assertions check on every cycle that the grant is one-hot, that a pending scanner keeps the bridge out of an idle bus, and that an ending tenure is followed by a no-grant cycle. They also check that a running bridge tenure is not broken, that the beat count stays within the cap, and that a held grant implies an upstream request. Some behaviours show only in the bench's scenarios: the exact beat on which a bridge burst is cut, whether the error pulse appears for a cut burst but not for a burst whose last beat lands on the cap, and the order of tenures when both masters keep requesting. These are shown by a behavioural model that the bench compares against the outputs on every cycle.

// File: rtl/sba_pkg.sv
package sba_pkg;

  typedef enum logic [1:0] {
    HOLD_NONE = 2'd0,
    HOLD_SCN  = 2'd1,
    HOLD_BRG  = 2'd2
  } holder_e;

  // Bridge may compete only when the scanner has nothing pending.
  function automatic logic brg_eligible(input logic brg_req, input logic scn_pend);
    return brg_req & ~scn_pend;
  endfunction

  // True when the beat about to be counted is the last one the cap allows.
  function automatic logic at_cap(input int unsigned count, input int unsigned limit);
    return (count + 1) >= limit;
  endfunction

  // Grant bit position per holder.
  function automatic int unsigned holder_bit(input holder_e h);
    return (h == HOLD_BRG) ? 1 : 0;
  endfunction

endpackage

// File: rtl/sba_pick.sv
module sba_pick
  import sba_pkg::*;
(
  input  logic    scn_pend,
  input  logic    brg_req,
  output holder_e pick
);

  always_comb begin
    if (scn_pend) begin
      pick = HOLD_SCN;
    end else if (brg_eligible(brg_req, scn_pend)) begin
      pick = HOLD_BRG;
    end else begin
      pick = HOLD_NONE;
    end
  end

endmodule

// File: rtl/sba_beat_cnt.sv
module sba_beat_cnt #(
  parameter int MAX_BEATS = 8,
  parameter int CNT_W     = $clog2(MAX_BEATS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             beat_en,
  input  logic             last,
  output logic [CNT_W-1:0] count,
  output logic             cap_hit,
  output logic             overrun
);

  logic [CNT_W-1:0] count_q;
  logic             overrun_q;

  always_comb begin
    cap_hit = beat_en & at_cap_w(count_q);
  end

  function automatic logic at_cap_w(input logic [CNT_W-1:0] c);
    return sba_pkg::at_cap(int'(unsigned'(c)), MAX_BEATS);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      overrun_q <= 1'b0;
    end else begin
      overrun_q <= cap_hit & ~last;
      if (clear) begin
        count_q <= '0;
      end else if (beat_en) begin
        count_q <= count_q + 1'b1;
      end
    end
  end

  assign count   = count_q;
  assign overrun = overrun_q;

endmodule

// File: rtl/sba_tenure.sv
module sba_tenure
  import sba_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  holder_e pick,
  input  logic    scn_pend,
  input  logic    scn_last,
  input  logic    brg_req,
  input  logic    brg_beat,
  input  logic    brg_last,
  input  logic    cap_hit,
  output holder_e holder,
  output logic    scn_end,
  output logic    brg_end,
  output logic    tenure_end,
  output logic    brg_start,
  output logic    bus_req
);

  holder_e holder_q, holder_d;
  logic    bus_req_q;

  always_comb begin
    scn_end    = (holder_q == HOLD_SCN) & scn_last;
    brg_end    = (holder_q == HOLD_BRG) & brg_beat & (brg_last | cap_hit);
    tenure_end = scn_end | brg_end;
    brg_start  = (holder_q == HOLD_NONE) & (pick == HOLD_BRG);
    case (holder_q)
      HOLD_NONE: holder_d = pick;
      HOLD_SCN:  holder_d = scn_end ? HOLD_NONE : HOLD_SCN;
      HOLD_BRG:  holder_d = brg_end ? HOLD_NONE : HOLD_BRG;
      default:   holder_d = HOLD_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holder_q  <= HOLD_NONE;
      bus_req_q <= 1'b0;
    end else begin
      holder_q  <= holder_d;
      bus_req_q <= (holder_d != HOLD_NONE) | scn_pend | brg_req;
    end
  end

  assign holder  = holder_q;
  assign bus_req = bus_req_q;

endmodule

// File: rtl/sysbus_arbiter.sv
module sysbus_arbiter
  import sba_pkg::*;
#(
  parameter  int MAX_BEATS = 8,
  localparam int CNT_W     = $clog2(MAX_BEATS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scn_pend,
  input  logic             scn_last,
  input  logic             brg_req,
  input  logic             brg_beat,
  input  logic             brg_last,
  output logic [1:0]       gnt,
  output logic             sys_bus_req,
  output logic             burst_err,
  output logic [CNT_W-1:0] brg_beats
);

  holder_e pick;
  holder_e holder;
  logic    scn_end, brg_end, tenure_end, brg_start;
  logic    beat_en, cap_hit;

  sba_pick u_pick (
    .scn_pend (scn_pend),
    .brg_req  (brg_req),
    .pick     (pick)
  );

  sba_tenure u_tenure (
    .clk        (clk),
    .rst_n      (rst_n),
    .pick       (pick),
    .scn_pend   (scn_pend),
    .scn_last   (scn_last),
    .brg_req    (brg_req),
    .brg_beat   (brg_beat),
    .brg_last   (brg_last),
    .cap_hit    (cap_hit),
    .holder     (holder),
    .scn_end    (scn_end),
    .brg_end    (brg_end),
    .tenure_end (tenure_end),
    .brg_start  (brg_start),
    .bus_req    (sys_bus_req)
  );

  assign beat_en = (holder == HOLD_BRG) & brg_beat;

  sba_beat_cnt #(
    .MAX_BEATS (MAX_BEATS),
    .CNT_W     (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (brg_start),
    .beat_en (beat_en),
    .last    (brg_last),
    .count   (brg_beats),
    .cap_hit (cap_hit),
    .overrun (burst_err)
  );

  for (genvar g = 0; g < 2; g++) begin : g_gnt
    assign gnt[g] = (holder != HOLD_NONE) && (holder_bit(holder) == g);
  end

endmodule

// File: rtl/sba_arbiter_chk.sv
module sba_arbiter_chk #(
  parameter int MAX_BEATS = 8,
  parameter int CNT_W     = $clog2(MAX_BEATS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scn_pend,
  input logic [1:0]       gnt,
  input logic             sys_bus_req,
  input logic             burst_err,
  input logic [CNT_W-1:0] brg_beats,
  input logic             brg_end,
  input logic             tenure_end
);

  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r2_scn_first: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == 2'b00 && scn_pend) |=> (gnt == 2'b01));

  a_r3_brg_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == 2'b00 && scn_pend) |=> !gnt[1]);

  a_r4_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[1] && !brg_end) |=> gnt[1]);

  a_r6_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != 2'b00 && tenure_end) |=> (gnt == 2'b00));

  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(unsigned'(brg_beats)) <= MAX_BEATS));

  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    burst_err |-> (gnt == 2'b00 && int'(unsigned'(brg_beats)) == MAX_BEATS));

  a_r10_req_with_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != 2'b00) |-> sys_bus_req);

endmodule

bind sysbus_arbiter sba_arbiter_chk #(
  .MAX_BEATS (MAX_BEATS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scn_pend    (scn_pend),
  .gnt         (gnt),
  .sys_bus_req (sys_bus_req),
  .burst_err   (burst_err),
  .brg_beats   (brg_beats),
  .brg_end     (brg_end),
  .tenure_end  (tenure_end)
);

// File: tb/tb_sysbus_arbiter.sv
module tb_sysbus_arbiter;

  localparam int MAXB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scn_pend = 1'b0, scn_last = 1'b0;
  logic brg_req = 1'b0, brg_beat = 1'b0, brg_last = 1'b0;
  logic [1:0] gnt;
  logic       sys_bus_req, burst_err;
  logic [3:0] brg_beats;

  always #2.5 clk = ~clk;

  sysbus_arbiter #(.MAX_BEATS(MAXB)) dut (
    .clk(clk), .rst_n(rst_n), .scn_pend(scn_pend), .scn_last(scn_last),
    .brg_req(brg_req), .brg_beat(brg_beat), .brg_last(brg_last),
    .gnt(gnt), .sys_bus_req(sys_bus_req), .burst_err(burst_err),
    .brg_beats(brg_beats)
  );

  // Behavioural reference: who owns the bus (0 none, 1 scanner, 2 bridge)
  int    m_owner = 0;
  int    m_beats = 0;
  bit    m_err = 0;
  bit    m_req = 0;
  int    compared = 0;
  int    mismatched = 0;
  int    cycles = 0;
  string phase = "R1 reset";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_owner = 0; m_beats = 0; m_err = 0; m_req = 0;
    end else begin
      int nxt;
      nxt = m_owner;
      m_err = 0;
      if (m_owner == 1 && scn_last) nxt = 0;
      if (m_owner == 2 && brg_beat) begin
        m_beats++;
        if (brg_last || m_beats == MAXB) nxt = 0;
        m_err = (m_beats == MAXB) && !brg_last;
      end
      if (m_owner == 0) begin
        if (scn_pend) nxt = 1;
        else if (brg_req) begin nxt = 2; m_beats = 0; end
      end
      m_req = (nxt != 0) || scn_pend || brg_req;
      m_owner = nxt;
    end
  end

  always @(negedge clk) begin
    logic [1:0] eg;
    eg = (m_owner == 1) ? 2'b01 : (m_owner == 2) ? 2'b10 : 2'b00;
    compared++;
    if (gnt !== eg || sys_bus_req !== m_req || burst_err !== m_err ||
        brg_beats !== 4'(m_beats)) begin
      mismatched++;
      $display("FAIL %s t=%0t: got gnt=%b req=%b err=%b beats=%0d, expected gnt=%b req=%b err=%b beats=%0d",
               phase, $time, gnt, sys_bus_req, burst_err, brg_beats,
               eg, m_req, m_err, m_beats);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: got %0d cycles, expected at most 100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic drive(input bit sp, input bit sl, input bit br, input bit bb, input bit bl);
    @(negedge clk);
    #1;
    scn_pend = sp; scn_last = sl; brg_req = br; brg_beat = bb; brg_last = bl;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0);
  endtask

  initial begin
    // R1: reset state, with requests already present
    scn_pend = 1'b1; brg_req = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    scn_pend = 1'b0; brg_req = 1'b0;
    rst_n = 1'b1;
    idle(3);

    // R6: scanner alone, tenure closed by its last
    phase = "R6 scanner tenure";
    drive(1, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 0);
    idle(3);

    // R2 / R3: both request from idle, scanner first, bridge waits
    phase = "R2 R3 scanner wins";
    drive(1, 0, 1, 0, 0);
    drive(1, 0, 1, 0, 0);
    drive(1, 0, 1, 0, 0);
    drive(0, 1, 1, 0, 0);
    drive(0, 0, 1, 0, 0);
    drive(0, 0, 1, 1, 0);
    drive(0, 0, 0, 1, 1);
    idle(3);

    // R4: scanner rises during a bridge burst, bridge keeps the bus
    phase = "R4 no preemption";
    drive(0, 0, 1, 0, 0);
    drive(0, 0, 1, 1, 0);
    drive(1, 0, 0, 1, 0);
    drive(1, 0, 0, 1, 0);
    drive(1, 0, 0, 0, 0);
    drive(1, 0, 0, 1, 0);
    drive(1, 0, 0, 1, 1);
    drive(1, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 0);
    idle(3);

    // R7 / R8: bridge never marks last, cap cuts at MAXB beats
    phase = "R7 R8 cap overrun";
    drive(0, 0, 1, 0, 0);
    for (int i = 0; i < MAXB + 2; i++) drive(0, 0, 1, 1, 0);
    drive(0, 0, 0, 0, 0);
    idle(3);

    // R8: last lands exactly on the cap, no error
    phase = "R8 last on cap";
    drive(0, 0, 1, 0, 0);
    for (int i = 0; i < MAXB - 1; i++) drive(0, 0, 1, 1, 0);
    drive(0, 0, 0, 1, 1);
    idle(3);

    // R9: gaps between beats, counter clears on the next grant
    phase = "R9 beat count";
    drive(0, 0, 1, 0, 0);
    for (int i = 0; i < 6; i++) drive(0, 0, 1, i[0], 0);
    drive(0, 0, 0, 1, 1);
    drive(0, 0, 1, 0, 0);
    drive(0, 0, 1, 0, 0);
    drive(0, 0, 0, 1, 1);
    idle(3);

    // R3 / R10: scanner pending without end, bridge starved
    phase = "R3 R10 bridge starved";
    for (int i = 0; i < 12; i++) drive(1, (i % 3) == 2, 1, 1, 1);
    idle(3);

    // R5 and all others: random traffic
    phase = "R5 random traffic";
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
            ($urandom_range(0, 1) == 1), ($urandom_range(0, 2) != 0),
            ($urandom_range(0, 9) == 0));
    end
    idle(4);

    // R1: reset in the middle of a bridge tenure
    phase = "R1 mid-tenure reset";
    drive(0, 0, 1, 0, 0);
    drive(0, 0, 1, 1, 0);
    @(negedge clk); #1;
    rst_n = 1'b0;
    idle(2);
    @(negedge clk); #1;
    rst_n = 1'b1;
    idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule